// File: doc/BRIEF.md
# Two-Bit Counter with Single-Digit Segment Driver

This block is a two-bit synchronous up-counter whose state is shown on one seven-segment digit. On every rising clock edge the count steps 0, 1, 2, 3 and then returns to 0. No enable input exists, so the count advances on every edge. A synchronous clear input forces the count back to 0 at the next edge.

The seven segment outputs are decoded combinationally from the current count and from the clear input. While clear is high, the whole digit is dark, and it shows no zero. Once clear is released, the digit shows the current count. The segments are active-high: a 1 lights a segment. The count is also brought out as a port, so a parent block can observe the state directly.

Top module: `digit_counter`

## Requirements
- R1: When `rstIn` is 1 at a rising clock edge, `countOut` is 0 after that edge, whatever its value before the edge.
- R2: When `rstIn` is 0 at a rising clock edge, `countOut` increases by one at that edge. The low bit inverts, and the new high bit is the XOR of the old high bit and the old low bit.
- R3: From count 3, with `rstIn` at 0, the next edge gives count 0 (wrap).
- R4: With `rstIn` at 0, `segOut` (bit 6 = segment A down to bit 0 = segment G) is 7'b1111110 for count 0, 7'b0110000 for count 1, 7'b1101101 for count 2 and 7'b1111001 for count 3. A 1 lights the segment.
- R5: While `rstIn` is 1, all seven bits of `segOut` are 0 in that same cycle, with no wait for a clock edge.
- R6: Segment B (`segOut[5]`) is always the inverse of `rstIn`.
- R7: Segment G (`segOut[0]`) is 1 only when `rstIn` is 0 and the count's high bit is 1. Segment E (`segOut[2]`) is 1 only when `rstIn` is 0 and the count's low bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstIn | input | 1 | Synchronous clear of the count; also blanks the digit at once |
| countOut | output | 2 | Current count, 0 to 3 |
| segOut | output | 7 | Active-high segments, bit 6 = A through bit 0 = G |

## Verification
The assertions assume that `rstIn` is held at 1 from time zero through the first rising edge. The count has no defined value before that edge. The assertions also assume that `rstIn` only changes away from the rising edge.

The bench meets both assumptions. It starts with clear high and changes it only on falling edges. The random part of the bench raises clear in about one cycle in five, and directed sequences raise it in each of the four states, so every transition is covered.

// File: rtl/digit_pkg.sv
package digit_pkg;
  localparam int CNT_W = 2;
  localparam int SEG_W = 7;
  localparam int DIGITS = 1 << CNT_W;

  // strobes passed from control to datapath
  typedef struct packed {
    logic clearCount;
    logic stepCount;
    logic blankOut;
  } ctrlStrobe_t;

  // segment pattern for one digit, bit 6 = A .. bit 0 = G, active-high
  function automatic logic [SEG_W-1:0] digitGlyph(input logic [CNT_W-1:0] value);
    logic [SEG_W-1:0] glyph;
    case (value)
      2'd0:    glyph = 7'b1111110;
      2'd1:    glyph = 7'b0110000;
      2'd2:    glyph = 7'b1101101;
      default: glyph = 7'b1111001;
    endcase
    return glyph;
  endfunction
endpackage

// File: rtl/digit_ctrl.sv
module digit_ctrl
  import digit_pkg::*;
(
  input  logic        rstIn,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.clearCount = rstIn;
    strobe.stepCount  = !rstIn;
    strobe.blankOut   = rstIn;
  end
endmodule

// File: rtl/digit_datapath.sv
module digit_datapath
  import digit_pkg::*;
(
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] countQ,
  output logic [SEG_W-1:0] segQ
);
  logic [CNT_W-1:0] countNext;
  logic [SEG_W-1:0] glyph;

  // next state: low bit inverts, high bit takes old high XOR old low
  always_comb begin
    countNext = countQ;
    if (strobe.clearCount) begin
      countNext = '0;
    end else if (strobe.stepCount) begin
      countNext[0] = ~countQ[0];
      countNext[1] = countQ[1] ^ countQ[0];
    end
  end

  always_ff @(posedge clk) begin
    countQ <= countNext;
  end

  always_comb begin
    glyph = digitGlyph(countQ);
  end

  // blanking gates every segment with the strobe
  genvar segIdx;
  generate
    for (segIdx = 0; segIdx < SEG_W; segIdx++) begin : g_seg
      assign segQ[segIdx] = glyph[segIdx] & ~strobe.blankOut;
    end
  endgenerate
endmodule

// File: rtl/digit_counter.sv
module digit_counter
  import digit_pkg::*;
(
  input  logic             clk,
  input  logic             rstIn,
  output logic [CNT_W-1:0] countOut,
  output logic [SEG_W-1:0] segOut
);
  ctrlStrobe_t strobe;

  digit_ctrl ctrl_i (
    .rstIn  (rstIn),
    .strobe (strobe)
  );

  digit_datapath dp_i (
    .clk    (clk),
    .strobe (strobe),
    .countQ (countOut),
    .segQ   (segOut)
  );
endmodule

// File: rtl/digit_counter_chk.sv
module digit_counter_chk
  import digit_pkg::*;
(
  input logic             clk,
  input logic             rstIn,
  input logic [CNT_W-1:0] countOut,
  input logic [SEG_W-1:0] segOut
);
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (rstIn) primed <= 1'b1;
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!primed)
    rstIn |=> countOut == '0); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!primed)
    !rstIn |=> countOut == CNT_W'($past(countOut) + 1'b1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!primed)
    (!rstIn && countOut == 2'd3) |=> countOut == 2'd0); // R3
  AST_ZERO_GLYPH: assert property (@(posedge clk) disable iff (!primed)
    (!rstIn && countOut == 2'd0) |-> segOut == 7'b1111110); // R4
  AST_BLANK_NOW: assert property (@(posedge clk) disable iff (!primed)
    rstIn |-> segOut == '0); // R5
  AST_SEG_B_INV: assert property (@(posedge clk) disable iff (!primed)
    segOut[5] == !rstIn); // R6
  AST_SEG_G_HIGH: assert property (@(posedge clk) disable iff (!primed)
    segOut[0] == (!rstIn && countOut[1])); // R7
endmodule

bind digit_counter digit_counter_chk chk_i (
  .clk      (clk),
  .rstIn    (rstIn),
  .countOut (countOut),
  .segOut   (segOut)
);

// File: tb/digit_counter_tb.sv
module digit_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstIn = 1'b1;
  logic [1:0] countOut;
  logic [6:0] segOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] expCount;
  logic       lastRst;

  always #10 clk = ~clk;

  digit_counter dut_i (
    .clk      (clk),
    .rstIn    (rstIn),
    .countOut (countOut),
    .segOut   (segOut)
  );

  function automatic logic [6:0] refGlyph(input logic [1:0] c, input logic r);
    logic [6:0] g;
    if (r) return 7'b0000000;
    case (c)
      2'd0: g = 7'b1111110;
      2'd1: g = 7'b0110000;
      2'd2: g = 7'b1101101;
      default: g = 7'b1111001;
    endcase
    return g;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive rst on falling edge, check, then advance the model for the next rising edge
  task automatic cycle(input logic r);
    logic [1:0] prevCount;
    @(negedge clk);
    prevCount = expCount;
    rstIn = r;
    #2;
    if (lastRst !== 1'b0) check("R1 count", {5'd0, countOut}, {5'd0, expCount});
    else if (expCount == 2'd0) check("R3 count", {5'd0, countOut}, {5'd0, expCount});
    else check("R2 count", {5'd0, countOut}, {5'd0, expCount});
    if (r) check("R5 segments", segOut, 7'd0);
    else check("R4 segments", segOut, refGlyph(expCount, 1'b0));
    check("R6 segB", {6'd0, segOut[5]}, {6'd0, ~r});
    check("R7 segG", {6'd0, segOut[0]}, {6'd0, ~r & expCount[1]});
    check("R7 segE", {6'd0, segOut[2]}, {6'd0, ~r & ~expCount[0]});
    lastRst = r;
    expCount = r ? 2'd0 : prevCount + 2'd1;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    expCount = 2'd0;
    lastRst = 1'b1;
    // reset state: first rising edge with rst high
    @(negedge clk);
    check("R1 reset count", {5'd0, countOut}, 7'd0);
    check("R5 reset blank", segOut, 7'd0);
    // four full wrap-arounds
    for (int i = 0; i < 16; i++) cycle(1'b0);
    // clear in every state
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < s; k++) cycle(1'b0);
      cycle(1'b1);
    end
    // back-to-back clear then release
    cycle(1'b1);
    cycle(1'b1);
    cycle(1'b0);
    // random mix
    for (int i = 0; i < 400; i++) cycle(($urandom % 5) == 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule